// File: doc/BRIEF.md
# Bit Test-and-Modify Memory Sequencer

This block carries out the memory half of four bit-manipulation instructions. Each instruction tests a memory operand against the accumulator and then either sets or clears the accumulator's bits in that operand. The surrounding core supplies the opcode, the operand bytes, the accumulator, the direct-page base, the data-bank byte and the accumulator-width flag, then pulses `start`. The sequencer forms the effective address and reads one byte or a little-endian word over a byte-wide synchronous memory port. It derives the zero flag from the unmodified operand ANDed with the accumulator, writes the modified operand back, and signals `done` in the last cycle of the instruction.

The memory port has a read latency of one clock. Data for a read issued in cycle k is sampled from `mem_rdata` in cycle k+1. The sequencer pads every instruction to its architectural cycle count, so `done` arrives in a cycle that software timing can rely on. States are `S_IDLE`, `S_RD_LO`, `S_RD_HI`, `S_WR_LO`, `S_WR_HI`, `S_PAD` and `S_DONE`. The transitions are as follows:
- IDLE→RD_LO on an accepted start.
- RD_LO→RD_HI for a word, or RD_LO→WR_LO for a byte.
- RD_HI→WR_LO.
- WR_LO→WR_HI for a word.
- WR_LO, WR_HI or PAD go to DONE when the next cycle is the final one, and to PAD otherwise.
- DONE→RD_LO on a back-to-back start, and DONE→IDLE otherwise.

Top module: `bitop_rmw_engine`

## Requirements
- R1: Four opcodes are accepted: 0x04 sets bits with direct-page addressing, 0x0C sets bits with absolute addressing, 0x14 clears bits with direct-page addressing, and 0x1C clears bits with absolute addressing. A `start` carrying any other opcode is ignored: `busy` stays low and no memory access occurs.
- R2: The direct-page effective address is the 16-bit `dpage` plus `operand[7:0]`, computed as a 24-bit sum with no wrap. The absolute effective address is `{dbank, operand}`.
- R3: `z_flag` becomes 1 when (original operand AND accumulator) is zero and 0 otherwise. It changes only in the cycle where `done` is high, and it holds its value at all other times. Its reset value is 0.
- R4: A set-bits opcode writes back the original operand OR the accumulator.
- R5: A clear-bits opcode writes back the original operand AND the inverted accumulator.
- R6: With `acc_narrow`=1, only the byte at the effective address is read and written, using `acc[7:0]`. The byte at address+1 is untouched.
- R7: With `acc_narrow`=0, the low byte is read at the address and the high byte at the address+1. The two bytes are then written in that same order. An address carry propagates into bit 16 and above.
- R8: No write strobe is issued until every read of the instruction has returned its data. A read and a write never occur in the same cycle.
- R9: Counting the cycle in which `start` is accepted as cycle 1, `done` is high in cycle N and `cyc_count` shows N. N is 5 for direct-page byte width, 6 for direct-page word width, 6 for absolute byte width and 7 for absolute word width.
- R10: A direct-page form adds one cycle to N when `dpage[7:0]` is nonzero. Absolute forms never add this cycle.
- R11: `done` is a one-cycle pulse. `busy` is high from the cycle after acceptance through the `done` cycle. A new `start` is accepted in the `done` cycle, so instructions run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (accepted when idle or in the done cycle) |
| opcode | input | 8 | Instruction opcode |
| operand | input | 16 | Operand bytes (offset in [7:0] for direct page, full address for absolute) |
| acc | input | 16 | Accumulator |
| dpage | input | 16 | Direct-page base |
| dbank | input | 8 | Data-bank byte for absolute addressing |
| acc_narrow | input | 1 | 1 = byte-wide accumulator, 0 = word-wide |
| mem_addr | output | 24 | Memory byte address |
| mem_rd | output | 1 | Read strobe; data is returned on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| z_flag | output | 1 | Zero result of the bit test |
| cyc_count | output | 4 | Cycle count of the last completed instruction |

## Verification
The `done` pulse of one instruction can coincide with the acceptance of the next `start`. In that cycle the first instruction's result is published in `z_flag` and `cyc_count`, while the second instruction latches its operands. The bench provokes this by raising `start` in the very cycle in which it observes `done`. The second instruction is chosen to operate on the byte that the first one just wrote. The scoreboard then requires the first result to be intact, the second result to be computed from the first result's memory contents, and the second `done` to fall exactly N cycles after that overlapping cycle.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_LO,
        S_RD_HI,
        S_WR_LO,
        S_WR_HI,
        S_PAD,
        S_DONE
    } bitop_state_t;

    typedef struct packed {
        logic valid;
        logic set_bits;
        logic absolute;
    } bitop_kind_t;

    localparam logic [7:0] OPC_SET_DP  = 8'h04;
    localparam logic [7:0] OPC_SET_ABS = 8'h0C;
    localparam logic [7:0] OPC_CLR_DP  = 8'h14;
    localparam logic [7:0] OPC_CLR_ABS = 8'h1C;

    localparam int CYC_DP_BYTE  = 5;
    localparam int CYC_DP_WORD  = 6;
    localparam int CYC_ABS_BYTE = 6;
    localparam int CYC_ABS_WORD = 7;
    localparam int CYC_MIN      = 5;
    localparam int CYC_MAX      = 7;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
#(
    parameter int OPC_W = 8
) (
    input  logic [OPC_W-1:0] opcode,
    output bitop_kind_t      kind
);

    always_comb begin
        kind = '0;
        unique case (opcode)
            OPC_SET_DP:  kind = '{valid: 1'b1, set_bits: 1'b1, absolute: 1'b0};
            OPC_SET_ABS: kind = '{valid: 1'b1, set_bits: 1'b1, absolute: 1'b1};
            OPC_CLR_DP:  kind = '{valid: 1'b1, set_bits: 1'b0, absolute: 1'b0};
            OPC_CLR_ABS: kind = '{valid: 1'b1, set_bits: 1'b0, absolute: 1'b1};
            default:     kind = '0;
        endcase
    end

endmodule

// File: rtl/bitop_addr.sv
module bitop_addr
    import bitop_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 24,
    parameter int CYC_W  = 4
) (
    input  bitop_kind_t             kind,
    input  logic                    narrow,
    input  logic [2*BYTE_W-1:0]     operand,
    input  logic [2*BYTE_W-1:0]     dpage,
    input  logic [ADDR_W-2*BYTE_W-1:0] dbank,
    output logic [ADDR_W-1:0]       eff_addr,
    output logic [CYC_W-1:0]        target
);

    localparam int WORD_W = 2 * BYTE_W;

    logic [ADDR_W-1:0] dp_addr;
    logic [ADDR_W-1:0] abs_addr;
    logic              dp_penalty;
    logic [CYC_W-1:0]  base_cyc;

    assign dp_addr    = ADDR_W'(dpage) + ADDR_W'(operand[BYTE_W-1:0]);
    assign abs_addr   = {dbank, operand};
    assign dp_penalty = |dpage[BYTE_W-1:0];

    always_comb begin
        unique case ({kind.absolute, narrow})
            2'b01:   base_cyc = CYC_W'(CYC_DP_BYTE);
            2'b00:   base_cyc = CYC_W'(CYC_DP_WORD);
            2'b11:   base_cyc = CYC_W'(CYC_ABS_BYTE);
            default: base_cyc = CYC_W'(CYC_ABS_WORD);
        endcase
    end

    assign eff_addr = kind.absolute ? abs_addr : dp_addr;
    assign target   = base_cyc + CYC_W'(!kind.absolute && dp_penalty);

    initial begin
        assert (WORD_W <= ADDR_W) else $error("address narrower than operand");
    end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu #(
    parameter int BYTE_W = 8
) (
    input  logic                  set_bits,
    input  logic                  narrow,
    input  logic [BYTE_W-1:0]     mem_lo,
    input  logic [BYTE_W-1:0]     mem_hi,
    input  logic [2*BYTE_W-1:0]   acc,
    output logic [2*BYTE_W-1:0]   result,
    output logic                  zero
);

    localparam int WORD_W = 2 * BYTE_W;

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] mask;

    always_comb begin
        if (narrow) begin
            word = {{BYTE_W{1'b0}}, mem_lo};
            mask = {{BYTE_W{1'b0}}, acc[BYTE_W-1:0]};
        end else begin
            word = {mem_hi, mem_lo};
            mask = acc;
        end
    end

    assign zero   = ~|(word & mask);
    assign result = set_bits ? (word | mask) : (word & ~mask);

endmodule

// File: rtl/bitop_fsm.sv
module bitop_fsm
    import bitop_pkg::*;
#(
    parameter int CYC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_valid,
    input  logic             wide_q,
    input  logic [CYC_W-1:0] target_q,
    output logic             accept,
    output bitop_state_t     state,
    output logic             finish,
    output logic             busy,
    output logic             done,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             hi_sel
);

    bitop_state_t     state_nx;
    logic [CYC_W-1:0] cnt;
    logic             last_next;

    assign accept    = start && op_valid && (state == S_IDLE || state == S_DONE);
    assign last_next = (cnt == target_q - CYC_W'(1));

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  state_nx = accept ? S_RD_LO : S_IDLE;
            S_RD_LO: state_nx = wide_q ? S_RD_HI : S_WR_LO;
            S_RD_HI: state_nx = S_WR_LO;
            S_WR_LO: state_nx = wide_q ? S_WR_HI : (last_next ? S_DONE : S_PAD);
            S_WR_HI: state_nx = last_next ? S_DONE : S_PAD;
            S_PAD:   state_nx = last_next ? S_DONE : S_PAD;
            S_DONE:  state_nx = accept ? S_RD_LO : S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (accept)
                cnt <= CYC_W'(2);
            else if (state != S_IDLE)
                cnt <= cnt + CYC_W'(1);
        end
    end

    always_comb begin
        busy   = 1'b1;
        done   = 1'b0;
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        hi_sel = 1'b0;
        unique case (state)
            S_IDLE:  busy = 1'b0;
            S_RD_LO: mem_rd = 1'b1;
            S_RD_HI: begin mem_rd = 1'b1; hi_sel = 1'b1; end
            S_WR_LO: mem_wr = 1'b1;
            S_WR_HI: begin mem_wr = 1'b1; hi_sel = 1'b1; end
            S_PAD:   ;
            S_DONE:  done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign finish = (state_nx == S_DONE);

    // R8: the first write follows all reads of the instruction
    a_r8_write_after_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !$past(mem_wr)) |-> ($past(mem_rd) && !mem_rd && (!wide_q || $past(mem_rd, 2))))
        else $error("write strobe before reads completed");

    // R11: done never lasts two cycles
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done held longer than one cycle");

    // R1: no memory traffic outside an instruction
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy)
        else $error("memory access while idle");

    // R9: completion lands on the latched cycle target
    a_r9_done_on_target: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt == target_q))
        else $error("done off the cycle target");

endmodule

// File: rtl/bitop_rmw_engine.sv
module bitop_rmw_engine
    import bitop_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 24,
    parameter int CYC_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [BYTE_W-1:0]          opcode,
    input  logic [2*BYTE_W-1:0]        operand,
    input  logic [2*BYTE_W-1:0]        acc,
    input  logic [2*BYTE_W-1:0]        dpage,
    input  logic [ADDR_W-2*BYTE_W-1:0] dbank,
    input  logic                       acc_narrow,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic                       mem_rd,
    output logic                       mem_wr,
    output logic [BYTE_W-1:0]          mem_wdata,
    input  logic [BYTE_W-1:0]          mem_rdata,
    output logic                       busy,
    output logic                       done,
    output logic                       z_flag,
    output logic [CYC_W-1:0]           cyc_count
);

    localparam int WORD_W = 2 * BYTE_W;

    bitop_kind_t       kind;
    logic [ADDR_W-1:0] ea_in;
    logic [CYC_W-1:0]  target_in;

    logic              accept;
    logic              finish;
    logic              hi_sel;
    bitop_state_t      state;

    logic [ADDR_W-1:0] ea_q;
    logic [WORD_W-1:0] acc_q;
    logic              wide_q;
    logic              set_q;
    logic [CYC_W-1:0]  target_q;
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] res_hi_q;
    logic              tz_q;

    logic [BYTE_W-1:0] alu_lo;
    logic [WORD_W-1:0] alu_res;
    logic              alu_zero;

    bitop_decode #(.OPC_W(BYTE_W)) u_decode (
        .opcode (opcode),
        .kind   (kind)
    );

    bitop_addr #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_addr (
        .kind     (kind),
        .narrow   (acc_narrow),
        .operand  (operand),
        .dpage    (dpage),
        .dbank    (dbank),
        .eff_addr (ea_in),
        .target   (target_in)
    );

    bitop_fsm #(.CYC_W(CYC_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_valid (kind.valid),
        .wide_q   (wide_q),
        .target_q (target_q),
        .accept   (accept),
        .state    (state),
        .finish   (finish),
        .busy     (busy),
        .done     (done),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .hi_sel   (hi_sel)
    );

    assign alu_lo = wide_q ? lo_q : mem_rdata;

    bitop_alu #(.BYTE_W(BYTE_W)) u_alu (
        .set_bits (set_q),
        .narrow   (!wide_q),
        .mem_lo   (alu_lo),
        .mem_hi   (mem_rdata),
        .acc      (acc_q),
        .result   (alu_res),
        .zero     (alu_zero)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q      <= '0;
            acc_q     <= '0;
            wide_q    <= 1'b0;
            set_q     <= 1'b0;
            target_q  <= CYC_W'(CYC_DP_BYTE);
            lo_q      <= '0;
            res_hi_q  <= '0;
            tz_q      <= 1'b0;
            z_flag    <= 1'b0;
            cyc_count <= '0;
        end else begin
            if (accept) begin
                ea_q     <= ea_in;
                acc_q    <= acc;
                wide_q   <= !acc_narrow;
                set_q    <= kind.set_bits;
                target_q <= target_in;
            end
            if (state == S_RD_HI)
                lo_q <= mem_rdata;
            if (state == S_WR_LO) begin
                res_hi_q <= alu_res[WORD_W-1:BYTE_W];
                tz_q     <= alu_zero;
            end
            if (finish) begin
                z_flag    <= tz_q;
                cyc_count <= target_q;
            end
        end
    end

    assign mem_addr  = hi_sel ? (ea_q + ADDR_W'(1)) : ea_q;
    assign mem_wdata = (state == S_WR_LO) ? alu_res[BYTE_W-1:0] : res_hi_q;

    // R7: the second access of a word targets the next byte address
    a_r7_hi_follows_lo: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd && $past(mem_rd)) || (mem_wr && $past(mem_wr)))
            |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)))
        else $error("high byte not at address plus one");

    // R9: reported count stays within the legal range
    a_r9_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc_count >= CYC_W'(CYC_MIN) && cyc_count <= CYC_W'(CYC_MAX + 1)))
        else $error("cycle count out of range");

    // R3: the zero flag moves only with done
    a_r3_z_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(z_flag) |-> done)
        else $error("zero flag changed outside done");

endmodule

// File: tb/bitop_rmw_engine_test.sv
module bitop_rmw_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [15:0] operand = '0;
    logic [15:0] acc = '0;
    logic [15:0] dpage = '0;
    logic [7:0]  dbank = '0;
    logic        acc_narrow = 1'b1;
    logic [23:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        busy;
    logic        done;
    logic        z_flag;
    logic [3:0]  cyc_count;

    int checks = 0;
    int errors = 0;
    int edges = 0;
    int rd_seen = 0;
    int wr_seen = 0;
    logic prev_done = 1'b0;

    typedef struct {
        logic [23:0] addr;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic        z;
        int          n;
        int          t0;
        logic        wide;
        string       tag;
    } item_t;

    item_t sbq[$];
    logic [7:0] bmem [int];
    logic [7:0] gmem [int];

    always #10 clk = ~clk;   // 50 MHz

    bitop_rmw_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .operand(operand),
        .acc(acc), .dpage(dpage), .dbank(dbank), .acc_narrow(acc_narrow),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .z_flag(z_flag), .cyc_count(cyc_count)
    );

    function automatic logic [7:0] bget(input int a);
        return bmem.exists(a) ? bmem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] gget(input int a);
        return gmem.exists(a) ? gmem[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        edges++;
        if (mem_rd) mem_rdata <= bget(int'(mem_addr));
        if (mem_wr) bmem[int'(mem_addr)] = mem_wdata;
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic preload(input int a, input logic [7:0] v);
        bmem[a] = v;
        gmem[a] = v;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_wr) begin
                wr_seen++;
                if (sbq.size() > 0)
                    chk("R8", "write before reads done", 32'(rd_seen < (sbq[0].wide ? 2 : 1)), 32'd0);
            end
            if (mem_rd) rd_seen++;
            if (prev_done && done) chk("R11", "done wider than one cycle", 32'd1, 32'd0);
            if (done) begin
                if (sbq.size() == 0) begin
                    chk("R11", "done with empty scoreboard", 32'd1, 32'd0);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    chk("R3", "z_flag", 32'(z_flag), 32'(it.z));
                    chk(it.tag, "cyc_count", 32'(cyc_count), 32'(it.n));
                    chk(it.tag, "done cycle index", 32'(edges + 1 - it.t0), 32'(it.n));
                    chk(it.tag, "low byte", 32'(bget(int'(it.addr))), 32'(it.lo));
                    chk(it.wide ? "R7" : "R6", "byte at addr+1", 32'(bget(int'(it.addr) + 1)), 32'(it.hi));
                    chk(it.wide ? "R7" : "R6", "bytes read", 32'(rd_seen), it.wide ? 32'd2 : 32'd1);
                    chk(it.wide ? "R7" : "R6", "bytes written", 32'(wr_seen), it.wide ? 32'd2 : 32'd1);
                end
                rd_seen = 0;
                wr_seen = 0;
            end
            prev_done = done;
        end
    end

    // driver: computes the expectation from the requirements and launches the instruction
    task automatic issue(input logic [7:0] op, input logic [15:0] opnd, input logic [15:0] a,
                         input logic [15:0] dp, input logic [7:0] db, input logic nar, input string tag);
        item_t it;
        logic set_b, absl;
        logic [15:0] w, m, r;
        logic [7:0] lo0, hi0;
        set_b = (op == 8'h04) || (op == 8'h0C);
        absl  = (op == 8'h0C) || (op == 8'h1C);
        it.addr = absl ? {db, opnd} : (24'(dp) + 24'(opnd[7:0]));
        it.n    = absl ? (nar ? 6 : 7) : ((nar ? 5 : 6) + ((dp[7:0] != 8'h00) ? 1 : 0));
        lo0 = gget(int'(it.addr));
        hi0 = gget(int'(it.addr) + 1);
        if (nar) begin w = {8'h00, lo0}; m = {8'h00, a[7:0]}; end
        else     begin w = {hi0, lo0};   m = a; end
        it.z  = ((w & m) == 16'h0000);
        r     = set_b ? (w | m) : (w & ~m);
        it.lo = r[7:0];
        it.hi = nar ? hi0 : r[15:8];
        it.wide = !nar;
        it.tag  = tag;
        it.t0   = edges;
        gmem[int'(it.addr)]     = it.lo;
        gmem[int'(it.addr) + 1] = it.hi;
        sbq.push_back(it);
        opcode = op; operand = opnd; acc = a; dpage = dp; dbank = db; acc_narrow = nar;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        acc = 16'hDEAD;   // changing inputs mid-instruction must not matter
        chk("R11", "busy after accept", 32'(busy), 32'd1);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        preload(24'h000010, 8'h0F); preload(24'h000011, 8'hA5);
        preload(24'h000234, 8'h0F);
        preload(24'h001310, 8'h00); preload(24'h001311, 8'h00);
        preload(24'h7EFFFF, 8'h5A); preload(24'h7F0000, 8'hC3);
        preload(24'h012000, 8'h81); preload(24'h012001, 8'h77);
        preload(24'h010010, 8'hFF); preload(24'h010011, 8'h3C);
        preload(24'h000050, 8'hF0); preload(24'h000051, 8'h12);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "reset busy", 32'(busy), 32'd0);
        chk("R11", "reset done", 32'(done), 32'd0);
        chk("R3",  "reset z_flag", 32'(z_flag), 32'd0);
        chk("R1",  "reset strobes", 32'({mem_rd, mem_wr}), 32'd0);

        // R4 R6: set bits, direct page, byte width, aligned base
        issue(8'h04, 16'h0010, 16'hFFF0, 16'h0000, 8'h00, 1'b1, "R4");
        wait_done(); @(negedge clk);
        // R5 R2: clear bits, direct page, high accumulator byte ignored
        issue(8'h14, 16'h0034, 16'hFF03, 16'h0200, 8'h00, 1'b1, "R5");
        wait_done(); @(negedge clk);
        // R10 R7: word width with misaligned direct page
        issue(8'h04, 16'h0090, 16'h8001, 16'h1280, 8'h00, 1'b0, "R10");
        wait_done(); @(negedge clk);
        // R7 R2: absolute word crossing into the next bank
        issue(8'h1C, 16'hFFFF, 16'hFF00, 16'h0000, 8'h7E, 1'b0, "R7");
        wait_done(); @(negedge clk);
        // R9 R10: absolute byte, misaligned direct page must not add a cycle
        issue(8'h0C, 16'h2000, 16'h0018, 16'h00FF, 8'h01, 1'b1, "R9");
        wait_done(); @(negedge clk);
        // R2 R10: direct-page sum carries past 16 bits
        issue(8'h14, 16'h0020, 16'h000F, 16'hFFF0, 8'h00, 1'b1, "R2");
        wait_done(); @(negedge clk);

        // R1: unknown opcode is ignored
        begin
            logic zb;
            zb = z_flag;
            opcode = 8'h42; operand = 16'h0050; acc = 16'hFFFF; acc_narrow = 1'b1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R1", "busy after unknown opcode", 32'(busy), 32'd0);
            for (int i = 0; i < 4; i++) begin
                chk("R1", "strobes after unknown opcode", 32'({mem_rd, mem_wr, done}), 32'd0);
                @(negedge clk);
            end
            chk("R1", "memory untouched", 32'(bget(24'h000050)), 32'hF0);
            chk("R3", "z held over ignored start", 32'(z_flag), 32'(zb));
        end

        // R11: back-to-back, second start in the done cycle on the same byte
        issue(8'h14, 16'h0050, 16'h00F0, 16'h0000, 8'h00, 1'b1, "R11");
        wait_done();
        issue(8'h04, 16'h0050, 16'h0081, 16'h0000, 8'h00, 1'b0, "R11");
        wait_done(); @(negedge clk);
        // R9: word direct page aligned, checks the 6-cycle case
        issue(8'h14, 16'h0050, 16'h0001, 16'h0000, 8'h00, 1'b0, "R9");
        wait_done();
        repeat (3) @(negedge clk);
        chk("R11", "scoreboard drained", 32'(sbq.size()), 32'd0);
        chk("R11", "idle at end", 32'(busy), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule